// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms 32-bit operand addresses for two register-relative addressing forms: a base register plus a sign-extended 16-bit displacement, and a base register plus a sign-extended 8-bit displacement plus an index register chosen by a compact 16-bit extension word. The index can be any of eight data registers or eight address registers. It can be used whole, or as its sign-extended low half.

A request is a single-cycle strobe. It carries the mode and an operand select, which names the source, the destination or both. With the strobe come the two base registers, both words of a two-word prefetch queue, and the flattened data and address register banks. The source result is loaded into address register 0 and the destination result into address register 1. A ready pulse follows one cycle later. Between requests, a bus sequencer can advance either address register by one word (2 bytes) per word transferred.

Top module: `idx_ea_unit`

## Requirements
- R1: After reset both address outputs are zero and `calc_ready` is low.
- R2: With `req_mode`=0 (displacement form), the result is the base plus the 16-bit extension word sign-extended to 32 bits.
- R3: With `req_sel`=2'b11, the source uses `pf_upper` and the destination uses `pf_lower`. With `req_sel`=2'b01 or 2'b10, the single operand uses `pf_lower`.
- R4: With `req_mode`=1 (indexed form), extension bit 15 picks the index bank: 1 means address registers (`areg_bank`), 0 means data registers (`dreg_bank`).
- R5: Extension bits 14:12 give the index register number n. Register n occupies bits [32n+31:32n] of its bank.
- R6: Extension bit 11 set uses the whole 32-bit index. Bit 11 clear uses bits 15:0 of the index, sign-extended to 32 bits.
- R7: In the indexed form, the result is the base plus the sign-extended extension bits 7:0 plus the index. Bits 10:8 have no effect.
- R8: `req_sel` bit 0 loads the source result into `ea_src`, and bit 1 loads the destination result into `ea_dst`. An output whose bit is clear keeps its value.
- R9: `calc_ready` is high exactly in the cycle after a cycle with `req_valid` high, whatever `req_sel` is, and low otherwise.
- R10: `step_src`/`step_dst` add 2 to `ea_src`/`ea_dst` on each clock. A load from a request in the same cycle takes priority over the step.
- R11: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_mode | input | 1 | 0 = 16-bit displacement, 1 = indexed brief form |
| req_sel | input | 2 | bit 0 = source, bit 1 = destination |
| src_base | input | 32 | Base register for the source operand |
| dst_base | input | 32 | Base register for the destination operand |
| pf_upper | input | 16 | Older prefetch word |
| pf_lower | input | 16 | Newer prefetch word |
| dreg_bank | input | 256 | Eight data registers, register n at [32n+31:32n] |
| areg_bank | input | 256 | Eight address registers, register n at [32n+31:32n] |
| step_src | input | 1 | Advance `ea_src` by 2 |
| step_dst | input | 1 | Advance `ea_dst` by 2 |
| ea_src | output | 32 | Source effective address |
| ea_dst | output | 32 | Destination effective address |
| calc_ready | output | 1 | Result-loaded pulse |

## Verification
Random requests mix both modes, all four select codes, full and half indices from either bank, and all register numbers. This shows whether the bank bit, the register number and the size bit each reach the sum. The both-operand select is run with different upper and lower prefetch words, so a swap of the slots changes both results. Directed cases use negative displacements and negative low-half indices to separate sign extension from zero extension, and use base values near 2^32 to expose carry handling. A step issued together with a load shows which one takes priority.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W   = 32;
  localparam int EXT_W    = 16;
  localparam int REG_CNT  = 8;
  localparam int REG_IDXW = $clog2(REG_CNT);
  localparam int STEP_B   = 2;
  localparam int OPND_CNT = 2;

  typedef enum logic {MODE_DISP16 = 1'b0, MODE_INDEXED = 1'b1} ea_mode_e;

  // Upper control bits of the compact extension word (bits 15:11).
  typedef struct packed {
    logic                use_areg;
    logic [REG_IDXW-1:0] reg_num;
    logic                long_idx;
  } brief_ctl_t;

  function automatic logic [ADDR_W-1:0] sx16(input logic [15:0] v);
    return {{(ADDR_W-16){v[15]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] sx8(input logic [7:0] v);
    return {{(ADDR_W-8){v[7]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] size_index(input logic [ADDR_W-1:0] r, input logic whole);
    return whole ? r : sx16(r[15:0]);
  endfunction
endpackage

// File: rtl/ea_index_sel.sv
module ea_index_sel
  import ea_pkg::*;
(
  input  brief_ctl_t                  ctl,
  input  logic [REG_CNT*ADDR_W-1:0]   dbank,
  input  logic [REG_CNT*ADDR_W-1:0]   abank,
  output logic [ADDR_W-1:0]           index_val
);
  logic [ADDR_W-1:0] dreg [REG_CNT];
  logic [ADDR_W-1:0] areg [REG_CNT];

  for (genvar i = 0; i < REG_CNT; i++) begin : g_unpack
    assign dreg[i] = dbank[i*ADDR_W +: ADDR_W];
    assign areg[i] = abank[i*ADDR_W +: ADDR_W];
  end

  logic [ADDR_W-1:0] raw;
  always_comb begin
    raw       = ctl.use_areg ? areg[ctl.reg_num] : dreg[ctl.reg_num];
    index_val = size_index(raw, ctl.long_idx);
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder
  import ea_pkg::*;
(
  input  ea_mode_e          mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [EXT_W-1:0]  ext,
  input  logic [ADDR_W-1:0] index_val,
  output logic [ADDR_W-1:0] sum
);
  always_comb begin
    if (mode == MODE_DISP16) sum = base + sx16(ext);
    else                     sum = base + sx8(ext[7:0]) + index_val;
  end
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import ea_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_mode,
  input  logic [1:0]                  req_sel,
  input  logic [ADDR_W-1:0]           src_base,
  input  logic [ADDR_W-1:0]           dst_base,
  input  logic [EXT_W-1:0]            pf_upper,
  input  logic [EXT_W-1:0]            pf_lower,
  input  logic [REG_CNT*ADDR_W-1:0]   dreg_bank,
  input  logic [REG_CNT*ADDR_W-1:0]   areg_bank,
  input  logic                        step_src,
  input  logic                        step_dst,
  output logic [ADDR_W-1:0]           ea_src,
  output logic [ADDR_W-1:0]           ea_dst,
  output logic                        calc_ready
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_B);

  ea_mode_e mode;
  assign mode = ea_mode_e'(req_mode);

  logic              dual;
  logic [1:0]        load_ea;
  logic [1:0]        step_ea;
  logic [ADDR_W-1:0] ea_q    [OPND_CNT];
  logic [ADDR_W-1:0] ea_next [OPND_CNT];
  logic [ADDR_W-1:0] base_v  [OPND_CNT];
  logic [EXT_W-1:0]  ext_v   [OPND_CNT];
  logic [ADDR_W-1:0] idx_v   [OPND_CNT];

  assign dual    = (req_sel == 2'b11);
  assign load_ea = {2{req_valid}} & req_sel;
  assign step_ea = {step_dst, step_src};
  assign base_v[0] = src_base;
  assign base_v[1] = dst_base;
  assign ext_v[0]  = dual ? pf_upper : pf_lower;
  assign ext_v[1]  = pf_lower;

  for (genvar g = 0; g < OPND_CNT; g++) begin : g_opnd
    brief_ctl_t ctl;
    assign ctl = brief_ctl_t'(ext_v[g][15:11]);

    ea_index_sel u_idx (
      .ctl       (ctl),
      .dbank     (dreg_bank),
      .abank     (areg_bank),
      .index_val (idx_v[g])
    );

    ea_adder u_add (
      .mode      (mode),
      .base      (base_v[g]),
      .ext       (ext_v[g]),
      .index_val (idx_v[g]),
      .sum       (ea_next[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)          ea_q[g] <= '0;
      else if (load_ea[g]) ea_q[g] <= ea_next[g];
      else if (step_ea[g]) ea_q[g] <= ea_q[g] + STEP_V;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) calc_ready <= 1'b0;
    else        calc_ready <= req_valid;
  end

  assign ea_src = ea_q[0];
  assign ea_dst = ea_q[1];
endmodule

// File: rtl/ea_checker.sv
module ea_checker
  import ea_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_mode,
  input logic [1:0]        req_sel,
  input logic [ADDR_W-1:0] src_base,
  input logic [EXT_W-1:0]  pf_lower,
  input logic [1:0]        load_ea,
  input logic [1:0]        step_ea,
  input logic [ADDR_W-1:0] ea_src,
  input logic [ADDR_W-1:0] ea_dst,
  input logic              calc_ready
);
  a_r9_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> calc_ready);
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !calc_ready);
  a_r8_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ea[0] && !step_ea[0]) |=> $stable(ea_src));
  a_r8_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ea[1] && !step_ea[1]) |=> $stable(ea_dst));
  a_r10_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ea[0] && step_ea[0]) |=> ea_src == $past(ea_src) + 32'd2);
  a_r10_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ea[1] && step_ea[1]) |=> ea_dst == $past(ea_dst) + 32'd2);
  a_r2_disp_src: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_mode && req_sel == 2'b01) |=>
      ea_src == $past(src_base) + {{16{$past(pf_lower[15])}}, $past(pf_lower)});
endmodule

bind idx_ea_unit ea_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .req_sel    (req_sel),
  .src_base   (src_base),
  .pf_lower   (pf_lower),
  .load_ea    (load_ea),
  .step_ea    (step_ea),
  .ea_src     (ea_src),
  .ea_dst     (ea_dst),
  .calc_ready (calc_ready)
);

// File: tb/idx_ea_unit_test.sv
`timescale 1ns/1ps
module idx_ea_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_mode, step_src, step_dst;
  logic [1:0] req_sel;
  logic [31:0] src_base, dst_base;
  logic [15:0] pf_upper, pf_lower;
  logic [255:0] dreg_bank, areg_bank;
  logic [31:0] ea_src, ea_dst;
  logic calc_ready;
  logic [31:0] dr [8];
  logic [31:0] ar [8];

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      dreg_bank[i*32 +: 32] = dr[i];
      areg_bank[i*32 +: 32] = ar[i];
    end
  end

  idx_ea_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_sel(req_sel), .src_base(src_base), .dst_base(dst_base),
    .pf_upper(pf_upper), .pf_lower(pf_lower), .dreg_bank(dreg_bank),
    .areg_bank(areg_bank), .step_src(step_src), .step_dst(step_dst),
    .ea_src(ea_src), .ea_dst(ea_dst), .calc_ready(calc_ready)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] m_src = 0, m_dst = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Reference address per requirements R2, R4-R7, R11.
  function automatic logic [31:0] ref_ea(input logic md, input logic [31:0] base, input logic [15:0] w);
    longint unsigned acc;
    logic [31:0] ix;
    logic signed [15:0] half;
    logic signed [7:0]  d8;
    if (!md) begin
      half = w;
      acc = longint'(base) + longint'(half);
    end else begin
      ix = w[15] ? ar[w[14:12]] : dr[w[14:12]];
      half = ix[15:0];
      d8 = w[7:0];
      acc = longint'(base) + longint'(d8) + (w[11] ? longint'(ix) : longint'(half));
    end
    return acc[31:0];
  endfunction

  task automatic request(input logic md, input logic [1:0] sel, input logic [31:0] sb,
                         input logic [31:0] db, input logic [15:0] hi, input logic [15:0] lo,
                         input string tag);
    @(negedge clk);
    req_valid = 1; req_mode = md; req_sel = sel;
    src_base = sb; dst_base = db; pf_upper = hi; pf_lower = lo;
    if (sel == 2'b11) begin
      m_src = ref_ea(md, sb, hi); m_dst = ref_ea(md, db, lo);
    end else begin
      if (sel[0]) m_src = ref_ea(md, sb, lo);
      if (sel[1]) m_dst = ref_ea(md, db, lo);
    end
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R8 src"}, ea_src, m_src);
    chk({tag, " R8 dst"}, ea_dst, m_dst);
    chk("R9 ready high", {31'd0, calc_ready}, 32'd1);
  endtask

  task automatic step(input logic s0, input logic s1);
    @(negedge clk);
    step_src = s0; step_dst = s1;
    if (s0) m_src = m_src + 2;
    if (s1) m_dst = m_dst + 2;
    @(negedge clk);
    step_src = 0; step_dst = 0;
    chk("R10 step src", ea_src, m_src);
    chk("R10 step dst", ea_dst, m_dst);
    chk("R9 ready low", {31'd0, calc_ready}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_ea01));
    rst_n = 0; req_valid = 0; req_mode = 0; req_sel = 0; step_src = 0; step_dst = 0;
    src_base = 0; dst_base = 0; pf_upper = 0; pf_lower = 0;
    for (int i = 0; i < 8; i++) begin
      dr[i] = 32'h1000_0000 * (i + 1) + 32'h0000_8000 + i;
      ar[i] = 32'h0100_0000 * (i + 1) + i * 3;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ea_src", ea_src, 0);
    chk("R1 ea_dst", ea_dst, 0);
    chk("R1 ready", {31'd0, calc_ready}, 0);

    // R2 / R11: negative displacement from zero wraps
    request(0, 2'b01, 32'h0, 32'h0, 16'h1234, 16'h8000, "R2 R11 neg disp");
    chk("R2 R11 value", ea_src, 32'hFFFF_8000);
    request(0, 2'b10, 32'h0, 32'hFFFF_FFFF, 16'h0, 16'h0002, "R11 carry wrap");
    chk("R11 value", ea_dst, 32'h0000_0001);
    // R3: both operands, different slots
    request(0, 2'b11, 32'h100, 32'h200, 16'h0010, 16'h0020, "R3 dual");
    chk("R3 src upper", ea_src, 32'h110);
    chk("R3 dst lower", ea_dst, 32'h220);
    // R4/R5/R6/R7: address bank reg 5 whole, disp8 = -128, bits 10:8 set
    request(1, 2'b01, 32'h0000_1000, 0, 16'h0, 16'hDF80, "R4 R5 R7 areg5 long");
    chk("R4 R5 R7 value", ea_src, 32'h0000_1000 - 128 + ar[5]);
    // R6: data reg 3 low half (0x8003 -> negative), disp8 = +4
    request(1, 2'b10, 0, 32'h0001_0000, 16'h0, 16'h3004, "R6 dreg3 short");
    chk("R6 value", ea_dst, 32'h0001_0000 + 4 + 32'hFFFF_8003);
    // R8: select none holds both outputs
    request(1, 2'b00, 32'hDEAD, 32'hBEEF, 16'h1111, 16'h2222, "R8 none");
    // R10: steps, then load wins over step
    step(1, 0);
    step(0, 1);
    step(1, 1);
    @(negedge clk);
    req_valid = 1; req_mode = 0; req_sel = 2'b01; src_base = 32'h40; pf_lower = 16'h0004;
    step_src = 1; m_src = 32'h44;
    @(negedge clk);
    req_valid = 0; step_src = 0;
    chk("R10 load beats step", ea_src, m_src);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      for (int i = 0; i < 8; i++) begin
        dr[i] = $urandom(); ar[i] = $urandom();
      end
      request(1'($urandom_range(0, 1)), s, $urandom(), $urandom(),
              16'($urandom()), 16'($urandom()), "R3 R4 R5 R6 R7 random");
      if ($urandom_range(0, 3) == 0) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule